// File: doc/BRIEF.md
# One-Way Multi-Channel Interprocessor Mailbox

This block carries messages and signals from a sending processor to a receiving processor in one direction only; two-way traffic uses two copies. It has eleven channels of four kinds. Channels 0 to 7 each hold one 32-bit data word. Channel 8 holds no data and only rings a doorbell. Channel 9 is a 32-entry word queue. Channel 10 is a 32-word shared block with a doorbell toward the receiver and an acknowledge back to the sender.

The sender has a write-only port. The receiver has a read/write port with a one-cycle read latency. Each channel has an enable bit and a pending bit. The receiver's single level-high interrupt is the OR of every pending bit whose enable is set. The sender gets its own acknowledge interrupt line for channel 10.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both interrupt lines are low, the enable and status registers read zero, and the queue status reads 0x100 (empty, count zero).
- R2: A sender write to word address 0..7 stores the word for that channel and sets status bit n. A receiver read of the same address returns the word one cycle later and leaves the status bit set.
- R3: A sender write to address 8 sets status bit 8 and stores nothing: a receiver read of address 8 returns zero.
- R4: The receiver enable register sits at address 12 (bit n for channel n). rxIrq is high exactly while some status bit and its enable bit are both set.
- R5: The receiver status register sits at address 13. Writing 1 to a sticky bit (0..8, 10) clears it. Writing 0 leaves it unchanged.
- R6: The sender pushes into the queue by writing address 9. The receiver pops by reading address 9 and gets words in push order. Status bit 9 is high while the queue holds data and cannot be cleared by writing.
- R7: Queue status at receiver address 14 holds the count in bits 5:0, empty in bit 8, full in bit 9, overflow in bit 10 and underflow in bit 11. Writing 1 to bit 10 or 11 clears that flag.
- R8: A push while full is dropped and sets overflow. A push and pop in the same cycle are each judged against the queue state before that cycle.
- R9: A pop while empty returns zero and sets underflow.
- R10: The sender writes block word i at address 64+i and the receiver reads it at 64+i. A sender write of bit 0 = 1 to address 10 sets the block doorbell, which reads as bit 0 of receiver address 15 and sets status bit 10.
- R11: Sender writes to the block words are ignored while the block doorbell is set.
- R12: A receiver write of bit 0 = 1 to address 15 while the doorbell is set clears the doorbell and status bit 10 and raises txAckIrq. A sender write of bit 0 = 1 to address 11 drops txAckIrq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txWrEn | input | 1 | Sender write strobe |
| txAddr | input | 7 | Sender word address |
| txWrData | input | 32 | Sender write data |
| rxWrEn | input | 1 | Receiver write strobe |
| rxRdEn | input | 1 | Receiver read strobe |
| rxAddr | input | 7 | Receiver word address |
| rxWrData | input | 32 | Receiver write data |
| rxRdData | output | 32 | Receiver read data, valid the cycle after rxRdEn |
| rxIrq | output | 1 | Combined receiver interrupt, level high |
| txAckIrq | output | 1 | Block acknowledge interrupt toward the sender |

## Verification
The hardest state to reach is a full queue taking one more push. That case needs 32 accepted pushes with no pop in between. The bench then drains all 32 entries to show that the 33rd word was really discarded and did not overwrite a slot. The block-locked window is the other awkward case. The bench rings the block doorbell and writes a word while it is held. It then acknowledges, clears the acknowledge, and reads the word back through the receiver port to show that the held write had no effect and that a later write does.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;
  localparam int FAST_CH  = 8;
  localparam int NUM_CH   = FAST_CH + 3;
  localparam int CH_BELL  = FAST_CH;
  localparam int CH_FIFO  = FAST_CH + 1;
  localparam int CH_BLK   = FAST_CH + 2;
  localparam int ADDR_W   = 7;

  // shared word addresses (sender side)
  localparam logic [ADDR_W-1:0] A_BELL    = 7'd8;
  localparam logic [ADDR_W-1:0] A_QUEUE   = 7'd9;   // push (tx) / pop (rx)
  localparam logic [ADDR_W-1:0] A_BLKRING = 7'd10;
  localparam logic [ADDR_W-1:0] A_ACKCLR  = 7'd11;
  // receiver side
  localparam logic [ADDR_W-1:0] A_ENABLE  = 7'd12;
  localparam logic [ADDR_W-1:0] A_STATUS  = 7'd13;
  localparam logic [ADDR_W-1:0] A_QSTAT   = 7'd14;
  localparam logic [ADDR_W-1:0] A_BLKACK  = 7'd15;

  typedef struct packed {
    logic [FAST_CH-1:0] fastWr;
    logic               qPush;
    logic               qPop;
    logic               blkWr;
    logic               rdReq;
  } strobe_t;
endpackage

// File: rtl/ipc_mailbox_ctrl.sv
module ipc_mailbox_ctrl
  import ipc_mailbox_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BLK_WORDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txWrEn,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxWrEn,
  input  logic              rxRdEn,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic [DATA_W-1:0] rxWrData,
  input  logic              qEmpty,
  input  logic              qFull,
  output strobe_t           strb,
  output logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] en,
  output logic              bell,
  output logic              ovf,
  output logic              unf,
  output logic              rxIrq,
  output logic              txAckIrq
);
  localparam int BIDX_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;

  logic [NUM_CH-1:0] stickyQ, stickyD, setVec;
  logic              ackQ;
  logic              pushReq, popReq, blkInRange;
  logic              ringReq, ackReq, ackClrReq, statW1c;

  // sender strobe decode
  for (genvar i = 0; i < FAST_CH; i++) begin : g_fastDec
    assign strb.fastWr[i] = txWrEn && (txAddr == ADDR_W'(i));
  end

  assign pushReq    = txWrEn && (txAddr == A_QUEUE);
  assign popReq     = rxRdEn && (rxAddr == A_QUEUE);
  assign blkInRange = txAddr[ADDR_W-1] &&
                      ({1'b0, txAddr[ADDR_W-2:0]} < ADDR_W'(BLK_WORDS));
  assign ringReq    = txWrEn && (txAddr == A_BLKRING) && txWrData[0];
  assign ackClrReq  = txWrEn && (txAddr == A_ACKCLR) && txWrData[0];
  assign ackReq     = rxWrEn && (rxAddr == A_BLKACK) && rxWrData[0];
  assign statW1c    = rxWrEn && (rxAddr == A_STATUS);

  assign strb.qPush = pushReq && !qFull;
  assign strb.qPop  = popReq && !qEmpty;
  assign strb.blkWr = txWrEn && blkInRange && !bell;
  assign strb.rdReq = rxRdEn;

  // sticky pending bits; the queue bit is derived, never stored
  always_comb begin
    setVec                   = '0;
    setVec[FAST_CH-1:0]      = strb.fastWr;
    setVec[CH_BELL]          = txWrEn && (txAddr == A_BELL);
    setVec[CH_BLK]           = ringReq && !bell;
    stickyD                  = stickyQ;
    if (statW1c) stickyD     = stickyD & ~rxWrData[NUM_CH-1:0];
    if (ackReq && bell) stickyD[CH_BLK] = 1'b0;
    stickyD                  = stickyD | setVec;
    stickyD[CH_FIFO]         = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyQ <= '0;
      en      <= '0;
      bell    <= 1'b0;
      ackQ    <= 1'b0;
      ovf     <= 1'b0;
      unf     <= 1'b0;
    end else begin
      stickyQ <= stickyD;
      if (rxWrEn && (rxAddr == A_ENABLE)) en <= rxWrData[NUM_CH-1:0];
      if (bell) begin
        if (ackReq) bell <= 1'b0;
      end else if (ringReq) begin
        bell <= 1'b1;
      end
      if (ackReq && bell)  ackQ <= 1'b1;
      else if (ackClrReq)  ackQ <= 1'b0;
      if (pushReq && qFull) ovf <= 1'b1;
      else if (rxWrEn && (rxAddr == A_QSTAT) && rxWrData[10]) ovf <= 1'b0;
      if (popReq && qEmpty) unf <= 1'b1;
      else if (rxWrEn && (rxAddr == A_QSTAT) && rxWrData[11]) unf <= 1'b0;
    end
  end

  always_comb begin
    pend          = stickyQ;
    pend[CH_FIFO] = !qEmpty;
  end

  assign rxIrq    = |(pend & en);
  assign txAckIrq = ackQ;

  logic unusedBits;
  assign unusedBits = ^{txWrData[DATA_W-1:1], BIDX_W[0]};
endmodule

// File: rtl/ipc_mailbox_dp.sv
module ipc_mailbox_dp
  import ipc_mailbox_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int BLK_WORDS  = 32,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] en,
  input  logic              bell,
  input  logic              ovf,
  input  logic              unf,
  output logic [DATA_W-1:0] rxRdData,
  output logic              qEmpty,
  output logic              qFull,
  output logic [CNT_W-1:0]  qCount
);
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int BIDX_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
  localparam int FIDX_W = (FAST_CH > 1) ? $clog2(FAST_CH) : 1;

  logic [DATA_W-1:0] fastReg [FAST_CH];
  logic [DATA_W-1:0] blkMem  [BLK_WORDS];
  logic [DATA_W-1:0] qMem    [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] rdNext;

  // fast channel data words
  for (genvar i = 0; i < FAST_CH; i++) begin : g_fast
    always_ff @(posedge clk) begin
      if (!rstN)               fastReg[i] <= '0;
      else if (strb.fastWr[i]) fastReg[i] <= txWrData;
    end
  end

  // shared block
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < BLK_WORDS; k++) blkMem[k] <= '0;
    end else if (strb.blkWr) begin
      blkMem[txAddr[BIDX_W-1:0]] <= txWrData;
    end
  end

  // word queue
  always_ff @(posedge clk) begin
    if (strb.qPush) qMem[wrPtr] <= txWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strb.qPush)
        wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strb.qPop)
        rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({strb.qPush, strb.qPop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  assign qEmpty = (qCount == '0);
  assign qFull  = (qCount == CNT_W'(FIFO_DEPTH));

  // receiver read mux
  always_comb begin
    rdNext = '0;
    if (rxAddr < ADDR_W'(FAST_CH)) begin
      rdNext = fastReg[rxAddr[FIDX_W-1:0]];
    end else if (rxAddr[ADDR_W-1]) begin
      if ({1'b0, rxAddr[ADDR_W-2:0]} < ADDR_W'(BLK_WORDS))
        rdNext = blkMem[rxAddr[BIDX_W-1:0]];
    end else begin
      case (rxAddr)
        A_QUEUE:  rdNext = qEmpty ? '0 : qMem[rdPtr];
        A_ENABLE: rdNext[NUM_CH-1:0] = en;
        A_STATUS: rdNext[NUM_CH-1:0] = pend;
        A_QSTAT: begin
          rdNext[CNT_W-1:0] = qCount;
          rdNext[8]         = qEmpty;
          rdNext[9]         = qFull;
          rdNext[10]        = ovf;
          rdNext[11]        = unf;
        end
        A_BLKACK: rdNext[0] = bell;
        default:  rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rxRdData <= '0;
    else if (strb.rdReq) rxRdData <= rdNext;
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int BLK_WORDS  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txWrEn,
  input  logic [6:0]        txAddr,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxWrEn,
  input  logic              rxRdEn,
  input  logic [6:0]        rxAddr,
  input  logic [DATA_W-1:0] rxWrData,
  output logic [DATA_W-1:0] rxRdData,
  output logic              rxIrq,
  output logic              txAckIrq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  strobe_t           strb;
  logic [NUM_CH-1:0] pend, en;
  logic              bell, ovf, unf, qEmpty, qFull;
  logic [CNT_W-1:0]  qCount;

  ipc_mailbox_ctrl #(.DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .txWrEn(txWrEn), .txAddr(txAddr), .txWrData(txWrData),
    .rxWrEn(rxWrEn), .rxRdEn(rxRdEn), .rxAddr(rxAddr), .rxWrData(rxWrData),
    .qEmpty(qEmpty), .qFull(qFull),
    .strb(strb), .pend(pend), .en(en), .bell(bell), .ovf(ovf), .unf(unf),
    .rxIrq(rxIrq), .txAckIrq(txAckIrq)
  );

  ipc_mailbox_dp #(
    .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .BLK_WORDS(BLK_WORDS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txAddr(txAddr), .txWrData(txWrData), .rxAddr(rxAddr),
    .pend(pend), .en(en), .bell(bell), .ovf(ovf), .unf(unf),
    .rxRdData(rxRdData), .qEmpty(qEmpty), .qFull(qFull), .qCount(qCount)
  );
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              txWrEn,
  input logic [6:0]        txAddr,
  input logic              rxWrEn,
  input logic              rxRdEn,
  input logic [6:0]        rxAddr,
  input logic [DATA_W-1:0] rxWrData,
  input logic [DATA_W-1:0] rxRdData,
  input logic              rxIrq,
  input logic              txAckIrq,
  input logic [CNT_W-1:0]  qCount,
  input logic              bell,
  input logic              unf
);
  logic pushHit, popHit, isFull, isEmpty;
  assign pushHit = txWrEn && (txAddr == 7'd9);
  assign popHit  = rxRdEn && (rxAddr == 7'd9);
  assign isFull  = ({{(32-CNT_W){1'b0}}, qCount} == FIFO_DEPTH);
  assign isEmpty = (qCount == '0);

  // R4: the interrupt can only rise after a write on either port
  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> $past(txWrEn || rxWrEn));

  // R7: the count never exceeds the depth
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    {{(32-CNT_W){1'b0}}, qCount} <= FIFO_DEPTH);

  // R8: a push into a full queue with no pop leaves the count unchanged
  assert_drop_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pushHit && isFull && !popHit) |=> qCount == $past(qCount));

  // R9: a pop of an empty queue reads zero and flags underflow
  assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (popHit && isEmpty) |=> (rxRdData == '0) && unf);

  // R12: an acknowledge while the doorbell is set frees the block and signals the sender
  assert_ack_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rxWrEn && (rxAddr == 7'd15) && rxWrData[0] && bell) |=> (txAckIrq && !bell));

  // R12: the sender acknowledge only rises when the doorbell was set
  assert_ack_needs_bell_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txAckIrq) |-> $past(bell));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
  .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .txWrEn(txWrEn), .txAddr(txAddr),
  .rxWrEn(rxWrEn), .rxRdEn(rxRdEn), .rxAddr(rxAddr), .rxWrData(rxWrData),
  .rxRdData(rxRdData), .rxIrq(rxIrq), .txAckIrq(txAckIrq),
  .qCount(qCount), .bell(bell), .unf(unf)
);

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txWrEn = 1'b0;
  logic [6:0]  txAddr = '0;
  logic [31:0] txWrData = '0;
  logic        rxWrEn = 1'b0;
  logic        rxRdEn = 1'b0;
  logic [6:0]  rxAddr = '0;
  logic [31:0] rxWrData = '0;
  logic [31:0] rxRdData;
  logic        rxIrq, txAckIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  ipc_mailbox dut (
    .clk(clk), .rstN(rstN), .txWrEn(txWrEn), .txAddr(txAddr), .txWrData(txWrData),
    .rxWrEn(rxWrEn), .rxRdEn(rxRdEn), .rxAddr(rxAddr), .rxWrData(rxWrData),
    .rxRdData(rxRdData), .rxIrq(rxIrq), .txAckIrq(txAckIrq)
  );

  // vector: {op, req, addr, data}; op 0 = sender write, 1 = receiver write, 2 = receiver read and compare
  typedef logic [44:0] vec_t;
  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    {2'd2, 4'd1,  7'd12, 32'h0},           // R1 enable clear
    {2'd2, 4'd1,  7'd13, 32'h0},           // R1 status clear
    {2'd2, 4'd1,  7'd14, 32'h100},         // R1 queue empty
    {2'd0, 4'd2,  7'd3,  32'hA5A50003},
    {2'd0, 4'd2,  7'd7,  32'h12345678},
    {2'd2, 4'd2,  7'd3,  32'hA5A50003},    // R2
    {2'd2, 4'd2,  7'd7,  32'h12345678},
    {2'd2, 4'd2,  7'd13, 32'h88},          // R2 read leaves pending
    {2'd0, 4'd3,  7'd8,  32'hFFFF},
    {2'd2, 4'd3,  7'd13, 32'h188},         // R3
    {2'd2, 4'd3,  7'd8,  32'h0},           // R3 no data
    {2'd1, 4'd5,  7'd13, 32'h8},
    {2'd2, 4'd5,  7'd13, 32'h180},         // R5 single bit cleared
    {2'd1, 4'd5,  7'd13, 32'h180},
    {2'd2, 4'd5,  7'd13, 32'h0},
    {2'd0, 4'd6,  7'd9,  32'h11},
    {2'd0, 4'd6,  7'd9,  32'h22},
    {2'd0, 4'd6,  7'd9,  32'h33},
    {2'd2, 4'd7,  7'd14, 32'h3},           // R7 count 3
    {2'd2, 4'd6,  7'd13, 32'h200},         // R6 queue pending
    {2'd2, 4'd6,  7'd9,  32'h11},          // R6 order
    {2'd2, 4'd6,  7'd9,  32'h22},
    {2'd2, 4'd6,  7'd9,  32'h33},
    {2'd2, 4'd7,  7'd14, 32'h100},
    {2'd2, 4'd6,  7'd13, 32'h0},
    {2'd0, 4'd10, 7'd64, 32'hCAFE0000},
    {2'd0, 4'd10, 7'd95, 32'hBEEF001F},
    {2'd2, 4'd10, 7'd64, 32'hCAFE0000},    // R10
    {2'd2, 4'd10, 7'd95, 32'hBEEF001F},
    {2'd0, 4'd10, 7'd10, 32'h1},
    {2'd2, 4'd10, 7'd13, 32'h400}          // R10 block doorbell pending
  };

  task automatic txWr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); txWrEn = 1'b1; txAddr = a; txWrData = d;
    @(negedge clk); txWrEn = 1'b0;
  endtask

  task automatic rxWr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); rxWrEn = 1'b1; rxAddr = a; rxWrData = d;
    @(negedge clk); rxWrEn = 1'b0;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic rxRd(input logic [6:0] a, input logic [31:0] exp, input int req);
    @(negedge clk); rxRdEn = 1'b1; rxAddr = a;
    @(negedge clk); rxRdEn = 1'b0;
    check(rxRdData, exp, req, $sformatf("read addr %0d", a));
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of both interrupt lines
    check({31'b0, rxIrq}, 32'h0, 1, "rxIrq in reset");
    check({31'b0, txAckIrq}, 32'h0, 1, "txAckIrq in reset");
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][44:43])
        2'd0: txWr(VEC[i][38:32], VEC[i][31:0]);
        2'd1: rxWr(VEC[i][38:32], VEC[i][31:0]);
        default: rxRd(VEC[i][38:32], VEC[i][31:0], int'(VEC[i][42:39]));
      endcase
    end

    // R4: pending block bell without enable keeps the line low, enabling raises it
    check({31'b0, rxIrq}, 32'h0, 4, "irq masked");
    rxWr(7'd12, 32'h400);
    check({31'b0, rxIrq}, 32'h1, 4, "irq enabled");

    // R12: acknowledge frees the block and signals the sender
    rxRd(7'd15, 32'h1, 12);
    rxWr(7'd15, 32'h1);
    check({31'b0, txAckIrq}, 32'h1, 12, "ack raised");
    check({31'b0, rxIrq}, 32'h0, 12, "block pending cleared");
    rxRd(7'd15, 32'h0, 12);
    txWr(7'd11, 32'h1);
    check({31'b0, txAckIrq}, 32'h0, 12, "ack cleared by sender");

    // R11: block write while the bell is held is ignored
    txWr(7'd10, 32'h1);
    txWr(7'd64, 32'h00000001);
    rxRd(7'd64, 32'hCAFE0000, 11);
    rxWr(7'd15, 32'h1);
    txWr(7'd11, 32'h1);
    txWr(7'd64, 32'h00000001);
    rxRd(7'd64, 32'h00000001, 11);

    // R6: queue interrupt follows occupancy, not write-one-to-clear
    rxWr(7'd12, 32'h200);
    txWr(7'd9, 32'h5A);
    check({31'b0, rxIrq}, 32'h1, 6, "queue irq while data");
    rxWr(7'd13, 32'h200);
    check({31'b0, rxIrq}, 32'h1, 6, "queue irq not cleared by write");
    rxRd(7'd9, 32'h5A, 6);
    check({31'b0, rxIrq}, 32'h0, 6, "queue irq drops at empty");

    // R8: 33 pushes into a 32-deep queue; the last is dropped
    for (int k = 0; k < 33; k++) txWr(7'd9, 32'h1000 + k);
    rxRd(7'd14, 32'h620, 8);
    for (int k = 0; k < 32; k++) rxRd(7'd9, 32'h1000 + k, 8);
    rxRd(7'd14, 32'h500, 8);
    rxWr(7'd14, 32'h400);
    rxRd(7'd14, 32'h100, 7);   // R7 overflow flag cleared

    // R9: pop while empty
    rxRd(7'd9, 32'h0, 9);
    rxRd(7'd14, 32'h900, 9);
    rxWr(7'd14, 32'h800);
    rxRd(7'd14, 32'h100, 9);

    // R4: fast channel interrupt, then cleared via status (R5)
    rxWr(7'd12, 32'h7FF);
    txWr(7'd0, 32'hDEAD0000);
    check({31'b0, rxIrq}, 32'h1, 4, "fast irq");
    rxWr(7'd13, 32'h1);
    check({31'b0, rxIrq}, 32'h0, 5, "fast irq cleared");

    finishRun();
  end
endmodule